// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Unit

This block is the arithmetic execution stage of a 64-bit packet-filter virtual machine. On each accepted cycle it takes one 8-bit opcode, the current destination register value, a source register value and a 32-bit immediate. One clock later it returns the new destination value together with a valid strobe. Register file access, fetch, memory and branch handling belong to the surrounding pipeline.

The opcode byte carries three fields. The low three bits pick the operand width: 32-bit or 64-bit arithmetic. Bit 3 picks the second operand: the immediate or the source register. The high nibble names one of fourteen operations. The unit supports:

- add, subtract and multiply;
- unsigned divide and remainder;
- OR, AND and XOR;
- move and negate;
- three shifts;
- byte-order conversion. For this operation bit 3 chooses the target endianness instead of the operand source.

An opcode the unit cannot execute raises a one-cycle illegal flag in place of the valid strobe, and the previous result is kept.

Top module: `pfvm_alu`

## Requirements
- R1: Opcode bits [2:0] select the class: 3'd4 is 32-bit arithmetic and 3'd7 is 64-bit arithmetic. Any other class value is illegal.
- R2: Opcode bit 3 = 1 selects `src_in` as the second operand, and bit 3 = 0 selects `imm`. In the 64-bit class the immediate is sign-extended from bit 31.
- R3: In the 32-bit class both operands are cut to their low 32 bits, and the result is zero-extended to 64 bits (`result[63:32]` = 0).
- R4: Opcode bits [7:4] select the operation. The codes are 0 add, 1 subtract, 2 multiply, 4 OR, 5 AND, 10 XOR and 11 move. Each result wraps modulo 2^width.
- R5: Code 3 is an unsigned divide. A zero divisor gives 0.
- R6: Code 9 is an unsigned remainder. A zero divisor returns the destination unchanged, truncated to 32 bits in the 32-bit class.
- R7: Code 6 shifts left and code 7 shifts right logically. The shift amount is the second operand masked to 5 bits (32-bit class) or 6 bits (64-bit class).
- R8: Code 12 is an arithmetic right shift that copies the sign bit of the operand width, with the same amount masking as R7.
- R9: Code 8 gives the two's-complement negation of the destination.
- R10: Code 13 in the 32-bit class is byte-order conversion of the destination, with width `imm` = 16, 32 or 64. Bit 3 = 0 (little endian) keeps the low width bits and clears the rest. Bit 3 = 1 (big endian) reverses the byte order inside the low width bits and clears the rest.
- R11: The following opcodes are illegal: codes 14 and 15, code 13 in the 64-bit class, and code 13 with any other width. An illegal opcode gives `illegal`=1 and `out_valid`=0 in the next cycle, and `result` keeps its previous value.
- R12: Outputs appear exactly one cycle after `in_valid`. A cycle without `in_valid` gives `out_valid`=0 and `illegal`=0. Reset clears `out_valid`, `illegal` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| opcode | input | 8 | Operation byte |
| dst_in | input | 64 | Current destination value |
| src_in | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| out_valid | output | 1 | `result` holds a new destination value |
| illegal | output | 1 | Previous operation was not executable |
| result | output | 64 | New destination value |

## Verification
Each operation is driven with operands that separate the behaviour choices from each other:

- Immediates with bit 31 set show whether sign extension happens in the 64-bit class and not in the 32-bit class.
- Destinations with nonzero upper halves show whether 32-bit truncation happens.
- Shift amounts above 31 and above 63 show whether the amount is masked.
- Negative operands separate arithmetic right shifts from logical ones.
- Zero divisors exercise the divide and remainder special cases.
- Byte-order conversion runs at all three widths in both directions, so clearing and reversal can be told apart.
- Illegal widths, classes and codes are interleaved with legal operations, which shows that the held result is not disturbed.

A seeded random stream of legal and illegal opcodes then compares the unit against the reference model on every cycle.

// File: rtl/pfvm_alu_pkg.sv
package pfvm_alu_pkg;

    localparam int XLEN   = 64;
    localparam int HALF   = XLEN / 2;
    localparam int IMM_W  = 32;
    localparam int NBYTES = XLEN / 8;

    localparam logic [2:0] CLS_NARROW = 3'd4;
    localparam logic [2:0] CLS_WIDE   = 3'd7;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL  = 4'h2, OP_DIV  = 4'h3,
        OP_OR   = 4'h4, OP_AND  = 4'h5, OP_SHL  = 4'h6, OP_SHR  = 4'h7,
        OP_NEG  = 4'h8, OP_REM  = 4'h9, OP_XOR  = 4'ha, OP_MOV  = 4'hb,
        OP_SAR  = 4'hc, OP_SWAP = 4'hd, OP_RSVE = 4'he, OP_RSVF = 4'hf
    } alu_op_e;

    typedef enum logic [1:0] {
        SWW_16 = 2'd0, SWW_32 = 2'd1, SWW_64 = 2'd2, SWW_BAD = 2'd3
    } swap_w_e;

    typedef struct packed {
        logic    legal;
        logic    wide;
        logic    use_reg;
        alu_op_e op;
        swap_w_e sw;
        logic    to_big;
    } dec_t;

    function automatic logic [XLEN-1:0] rev_low_bytes(
        input logic [XLEN-1:0] x, input int nb);
        logic [XLEN-1:0] r;
        r = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < nb) r[8*(nb-1-i) +: 8] = x[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pfvm_alu_decode.sv
module pfvm_alu_decode
    import pfvm_alu_pkg::*;
(
    input  logic [7:0]       opcode,
    input  logic [IMM_W-1:0] imm,
    output dec_t             dec
);
    logic    is_arith;
    alu_op_e op;
    swap_w_e sw;

    always_comb begin
        op       = alu_op_e'(opcode[7:4]);
        is_arith = (opcode[2:0] == CLS_NARROW) || (opcode[2:0] == CLS_WIDE);
        case (imm)
            32'd16:  sw = SWW_16;
            32'd32:  sw = SWW_32;
            32'd64:  sw = SWW_64;
            default: sw = SWW_BAD;
        endcase
        dec.wide    = (opcode[2:0] == CLS_WIDE);
        dec.use_reg = opcode[3];
        dec.to_big  = opcode[3];
        dec.op      = op;
        dec.sw      = sw;
        dec.legal   = is_arith && (op != OP_RSVE) && (op != OP_RSVF) &&
                      ((op != OP_SWAP) || (!dec.wide && sw != SWW_BAD));
    end
endmodule

// File: rtl/pfvm_alu_arith.sv
module pfvm_alu_arith
    import pfvm_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic         wide,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int SHW = $clog2(W);
    localparam int HW  = W / 2;

    logic [SHW-1:0] shamt;
    logic [W-1:0]   raw;
    logic [HW-1:0]  sar_half;
    logic           b_zero;

    always_comb begin
        shamt    = wide ? b[SHW-1:0] : {1'b0, b[SHW-2:0]};
        b_zero   = (b == '0);
        sar_half = HW'($signed(a[HW-1:0]) >>> shamt);
        case (op)
            OP_ADD:  raw = a + b;
            OP_SUB:  raw = a - b;
            OP_MUL:  raw = a * b;
            OP_DIV:  raw = b_zero ? '0 : a / b;
            OP_REM:  raw = b_zero ? a : a % b;
            OP_OR:   raw = a | b;
            OP_AND:  raw = a & b;
            OP_XOR:  raw = a ^ b;
            OP_SHL:  raw = a << shamt;
            OP_SHR:  raw = a >> shamt;
            OP_SAR:  raw = wide ? W'($signed(a) >>> shamt) : {{HW{1'b0}}, sar_half};
            OP_NEG:  raw = '0 - a;
            OP_MOV:  raw = b;
            default: raw = '0;
        endcase
        y = wide ? raw : {{HW{1'b0}}, raw[HW-1:0]};
    end
endmodule

// File: rtl/pfvm_alu_swap.sv
module pfvm_alu_swap
    import pfvm_alu_pkg::*;
(
    input  logic [XLEN-1:0] d,
    input  swap_w_e         sw,
    input  logic            to_big,
    output logic [XLEN-1:0] y
);
    localparam int NW = 3;

    logic [XLEN-1:0] le_v [NW];
    logic [XLEN-1:0] be_v [NW];

    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int BITS = 16 << g;
        assign le_v[g] = d & {{(XLEN-BITS){1'b0}}, {BITS{1'b1}}};
        assign be_v[g] = rev_low_bytes(d, BITS / 8);
    end

    always_comb begin
        case (sw)
            SWW_16:  y = to_big ? be_v[0] : le_v[0];
            SWW_32:  y = to_big ? be_v[1] : le_v[1];
            SWW_64:  y = to_big ? be_v[2] : le_v[2];
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/pfvm_alu.sv
module pfvm_alu
    import pfvm_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [7:0]      opcode,
    input  logic [XLEN-1:0] dst_in,
    input  logic [XLEN-1:0] src_in,
    input  logic [IMM_W-1:0] imm,
    output logic            out_valid,
    output logic            illegal,
    output logic [XLEN-1:0] result
);
    dec_t            dec;
    logic [XLEN-1:0] b_full, a_op, b_op, arith_y, swap_y, nxt;

    pfvm_alu_decode u_dec (.opcode(opcode), .imm(imm), .dec(dec));

    always_comb begin
        if (dec.use_reg)   b_full = src_in;
        else if (dec.wide) b_full = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        else               b_full = {{(XLEN-IMM_W){1'b0}}, imm};
        a_op = dec.wide ? dst_in : {{HALF{1'b0}}, dst_in[HALF-1:0]};
        b_op = dec.wide ? b_full : {{HALF{1'b0}}, b_full[HALF-1:0]};
    end

    pfvm_alu_arith #(.W(XLEN)) u_arith (
        .op(dec.op), .wide(dec.wide), .a(a_op), .b(b_op), .y(arith_y)
    );

    pfvm_alu_swap u_swap (
        .d(dst_in), .sw(dec.sw), .to_big(dec.to_big), .y(swap_y)
    );

    assign nxt = (dec.op == OP_SWAP) ? swap_y : arith_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid && dec.legal;
            illegal   <= in_valid && !dec.legal;
            if (in_valid && dec.legal) result <= nxt;
        end
    end
endmodule

// File: rtl/pfvm_alu_checker.sv
module pfvm_alu_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [7:0]  opcode,
    input logic        out_valid,
    input logic        illegal,
    input logic [63:0] result
);
    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && illegal));

    p_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !illegal));

    p_badclass_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[2:0] != 3'd4 && opcode[2:0] != 3'd7) |=> illegal);

    p_rsvcode_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (opcode[7:4] == 4'he || opcode[7:4] == 4'hf || opcode == 8'hd7)) |=> illegal);

    p_zext_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[2:0] == 3'd4 && opcode[7:4] < 4'hd) |=>
            (illegal || result[63:32] == 32'h0));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[7:4] == 4'he) |=> $stable(result));
endmodule

bind pfvm_alu pfvm_alu_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .out_valid(out_valid), .illegal(illegal), .result(result)
);

// File: tb/pfvm_alu_bench.sv
module pfvm_alu_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  opcode;
    logic [63:0] dst_in, src_in;
    logic [31:0] imm;
    logic        out_valid, illegal;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] last_res;

    always #2.5 clk = ~clk;

    pfvm_alu u_pfvm_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .dst_in(dst_in), .src_in(src_in), .imm(imm),
        .out_valid(out_valid), .illegal(illegal), .result(result)
    );

    // behavioural reference: returns legality through ok
    function automatic logic [63:0] model(input logic [7:0] op, input logic [63:0] d,
        input logic [63:0] s, input logic [31:0] k, output bit ok);
        longint unsigned x, y, r, m;
        int cls, code, amt, nb;
        bit w64;
        cls = op & 7; code = op >> 4; w64 = (cls == 7);
        ok = (cls == 4 || cls == 7) && code < 14;
        m = w64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        x = d & m;
        if (op[3]) y = s & m;
        else y = (w64 ? {{32{k[31]}}, k} : {32'h0, k}) & m;
        amt = w64 ? int'(y % 64) : int'(y % 32);
        r = 0;
        case (code)
            0: r = x + y;
            1: r = x - y;
            2: r = x * y;
            3: r = (y == 0) ? 0 : x / y;
            4: r = x | y;
            5: r = x & y;
            6: r = x << amt;
            7: r = x >> amt;
            8: r = -x;
            9: r = (y == 0) ? x : x % y;
            10: r = x ^ y;
            11: r = y;
            12: begin
                if (w64) r = longint'($signed(x) >>> amt);
                else r = {32'h0, 32'($signed(x[31:0]) >>> amt)};
            end
            13: begin
                if (w64 || !(k == 16 || k == 32 || k == 64)) ok = 0;
                else begin
                    nb = k / 8;
                    for (int i = 0; i < nb; i++) begin
                        if (op[3]) r[8*(nb-1-i) +: 8] = d[8*i +: 8];
                        else r[8*i +: 8] = d[8*i +: 8];
                    end
                end
            end
            default: ok = 0;
        endcase
        return r & m | (code == 13 ? r : 64'h0);
    endfunction

    task automatic compare(input logic ev, input logic ei, input logic [63:0] er, input string tag);
        checks++;
        if (out_valid !== ev || illegal !== ei || result !== er) begin
            errors++;
            $display("FAIL %s: got v=%0b ill=%0b res=%h expected v=%0b ill=%0b res=%h",
                     tag, out_valid, illegal, result, ev, ei, er);
        end
    endtask

    task automatic apply(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] k, input string tag);
        bit ok;
        logic [63:0] e;
        @(negedge clk);
        in_valid = 1; opcode = op; dst_in = d; src_in = s; imm = k;
        e = model(op, d, s, k, ok);
        @(posedge clk); #1;
        if (ok) last_res = e;
        compare(ok, !ok, last_res, tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 0; opcode = 8'hff;
        @(posedge clk); #1;
        compare(0, 0, last_res, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R12 watchdog: got hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; opcode = 0; dst_in = 0; src_in = 0; imm = 0;
        last_res = 0;
        repeat (3) @(posedge clk); #1;
        compare(0, 0, 64'h0, "R12 reset");
        @(negedge clk); rst = 0;
        idle("R12 idle");
        apply(8'h0f, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4 add64 wrap");
        apply(8'h07, 64'h10, 0, 32'hFFFF_FFFF, "R2 imm sext add64");
        apply(8'h04, 64'hAAAA_0000_FFFF_FFFF, 0, 32'h2, "R3 add32 trunc");
        apply(8'h0c, 64'h5, 64'hFFFF_FFFF_0000_0001, 0, "R2 reg src add32");
        apply(8'h1f, 64'h3, 64'h5, 0, "R4 sub64");
        apply(8'h27, 64'h1234_5678_9abc_def0, 0, 32'h0000_1001, "R4 mul64");
        apply(8'h24, 64'h0000_0001_8000_0001, 0, 32'h3, "R3 mul32");
        apply(8'h3f, 64'd1000, 64'd7, 0, "R5 div");
        apply(8'h3f, 64'd1000, 64'd0, 0, "R5 div zero");
        apply(8'h9f, 64'd1000, 64'd7, 0, "R6 mod");
        apply(8'h9f, 64'hDEAD_BEEF_0000_0009, 64'd0, 0, "R6 mod64 zero");
        apply(8'h94, 64'hDEAD_BEEF_0000_0009, 0, 0, "R6 mod32 zero");
        apply(8'h4f, 64'hF0, 64'h0F, 0, "R4 or");
        apply(8'h57, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'h8000_00FF, "R4 and sext");
        apply(8'haf, 64'hFF00, 64'h0FF0, 0, "R4 xor");
        apply(8'h6f, 64'h1, 64'd65, 0, "R7 shl64 mask");
        apply(8'h64, 64'h1, 0, 32'd33, "R7 shl32 mask");
        apply(8'h7f, 64'h8000_0000_0000_0000, 64'd63, 0, "R7 shr64");
        apply(8'hc7, 64'h8000_0000_0000_0000, 0, 32'd4, "R8 sar64");
        apply(8'hc4, 64'h1234_5678_8000_0000, 0, 32'd36, "R8 sar32");
        apply(8'h87, 64'h5, 0, 0, "R9 neg64");
        apply(8'h84, 64'h1_0000_0001, 0, 0, "R9 neg32");
        apply(8'hb7, 64'h0, 0, 32'hFFFF_FFFE, "R2 mov64 imm");
        apply(8'hb4, 64'h0, 0, 32'hFFFF_FFFE, "R2 mov32 imm");
        apply(8'hd4, 64'h1122_3344_5566_7788, 0, 32'd16, "R10 le16");
        apply(8'hd4, 64'h1122_3344_5566_7788, 0, 32'd32, "R10 le32");
        apply(8'hd4, 64'h1122_3344_5566_7788, 0, 32'd64, "R10 le64");
        apply(8'hdc, 64'h1122_3344_5566_7788, 0, 32'd16, "R10 be16");
        apply(8'hdc, 64'h1122_3344_5566_7788, 0, 32'd32, "R10 be32");
        apply(8'hdc, 64'h1122_3344_5566_7788, 0, 32'd64, "R10 be64");
        apply(8'hdc, 64'h1, 0, 32'd8, "R11 bad width");
        apply(8'hd7, 64'h1, 0, 32'd16, "R11 swap wide");
        apply(8'he4, 64'h1, 0, 0, "R11 code e");
        apply(8'hf7, 64'h1, 0, 0, "R11 code f");
        apply(8'h05, 64'h1, 0, 0, "R1 class 5");
        apply(8'h00, 64'h1, 0, 0, "R1 class 0");
        idle("R12 idle after");
        for (int n = 0; n < 400; n++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if (n % 4 != 0) op[2:0] = (n % 2) ? 3'd7 : 3'd4;
            apply(op, {$urandom, $urandom}, {$urandom, $urandom},
                  (n % 5 == 0) ? 32'd16 << (n % 3) : $urandom % 80,
                  "R4 R12 random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule